// File: doc/BRIEF.md
# Ultra DMA Data-In Burst Sender

This block is the device half of an Ultra DMA mode 4 read burst on a 16-bit parallel disk bus. A local source that behaves like a show-ahead FIFO offers words. After a start pulse with a non-zero word count, the engine raises its DMA request and waits for the host acknowledge. It then takes over the data lines and the strobe line. Each strobe transition, falling or rising, hands the host one word, so one strobe period carries two words.

The engine obeys host flow control. It makes no strobe edge while the host's ready line is low, and it stops sending data as soon as the host raises STOP. When the word count runs out, the device ends the burst itself. It drops its request, holds the strobe until the host answers with STOP, returns the strobe to its high idle level, and then presents a CRC-16 of every word that was strobed. The bus is released a fixed number of cycles after the host withdraws its acknowledge.

All nanosecond limits are turned into cycle counts from a clock-period parameter. With the default 4 ns clock, strobe edges are 8 cycles (32 ns) apart, data setup and hold are 2 cycles each, and the post-acknowledge hold is 2 cycles.

Top module: `ubrst_sender`

## Requirements
- R1: After reset, `dmarq` and `bus_oe` are 0, `dstrobe` is 1 and `src_take` is 0.
- R2: A `start` pulse in idle with a non-zero `word_cnt` raises `dmarq` one cycle later. A start with a zero count is ignored.
- R3: The bus stays undriven while `dmack` is low or `host_stop` is high. One cycle after the edge that samples `dmack`=1 with `host_stop`=0, `bus_oe` is 1 and `dstrobe` is 1.
- R4: Every `dstrobe` transition while `dmarq` is high delivers exactly one word, in source order. Each word's `src_take` pop coincides with its edge, and a burst ended by the device carries exactly `word_cnt` words.
- R5: Any two `dstrobe` transitions are at least HALF_CYC = ceil(30 ns / clock period) cycles apart.
- R6: `dd_out` is unchanged for at least SETUP_CYC = ceil(6 ns / period) cycles before each strobe transition. It does not change for HOLD_CYC = ceil(6 ns / period) cycles after the transition.
- R7: A strobe transition during transfer happens only if `host_rdy` was sampled high at the edge that produces it.
- R8: `host_stop` sampled high during transfer drops `dmarq` at that edge, and no further word is sent. Words not sent stay in the source without being popped.
- R9: When the count reaches zero, `dmarq` drops and `dstrobe` holds its level until `host_stop` is seen. The strobe then returns high, and that edge carries no word.
- R10: After the strobe is back high, `dd_out` holds the CRC-16 (polynomial 0x1021, seed 0x4ABA, each word fed most significant bit first) of all strobed words. It stays there until `dmack` falls.
- R11: `bus_oe` falls exactly CVH_CYC = ceil(6.2 ns / period) cycles after the edge that samples `dmack` low, and the engine returns to idle.
- R12: In idle, `host_rdy` and `host_stop` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a burst (taken in idle only) |
| word_cnt | input | CNT_W | Number of words to send |
| src_valid | input | 1 | Source head word is valid |
| src_data | input | 16 | Source head word |
| src_take | output | 1 | Pop the source head (word strobed at this edge) |
| dmarq | output | 1 | DMA request to host |
| dmack | input | 1 | DMA acknowledge from host |
| host_rdy | input | 1 | Host ready; low requests a pause |
| host_stop | input | 1 | Host stop request |
| dstrobe | output | 1 | Device data strobe, idle high |
| dd_out | output | 16 | Data lines: words, then CRC |
| bus_oe | output | 1 | Drive enable for data and strobe lines |

## Verification
The assertions check on every cycle the timing rules of the strobe:
- the minimum spacing between edges;
- data stable across each edge;
- no edge without ready;
- each pop tied to an edge;
- the strobe frozen and the request low while waiting for STOP;
- the CRC word held steady.

Only the bench's scenarios can show the end-to-end facts: words arrive in source order, the count is exact, and the CRC matches the words actually sent. They also show that unsent words survive a host stop, and that the release delay after acknowledge removal is exact.

// File: rtl/ubrst_pkg.sv
package ubrst_pkg;

  localparam int unsigned WORD_W = 16;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_XFER,
    ST_WSTOP,
    ST_PARK,
    ST_CRC,
    ST_REL
  } ubrst_st_e;

  // One 16-bit word folded into the CRC, most significant bit first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [WORD_W-1:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb = r[15] ^ d[i];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/ubrst_crc.sv
module ubrst_crc
  import ubrst_pkg::*;
#(
  parameter logic [15:0] SEED = 16'h4ABA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seed_ld,
  input  logic              upd,
  input  logic [WORD_W-1:0] word,
  output logic [15:0]       crc
);

  always_ff @(posedge clk) begin
    if (rst || seed_ld) crc <= SEED;
    else if (upd)       crc <= crc16_step(crc, word);
  end

endmodule

// File: rtl/ubrst_pace.sv
module ubrst_pace #(
  parameter int unsigned EDGE_CYC  = 8,
  parameter int unsigned HOLD_CYC  = 2,
  parameter int unsigned SETUP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_evt,
  input  logic load_evt,
  output logic edge_ok,
  output logic load_ok,
  output logic setup_ok
);

  localparam int unsigned GW = $clog2(EDGE_CYC + 1);
  localparam int unsigned SW = $clog2(SETUP_CYC + 1);

  logic [GW-1:0] gap;
  logic [SW-1:0] stg;

  // cycles since the last strobe edge, saturating
  always_ff @(posedge clk) begin
    if (rst)                           gap <= GW'(EDGE_CYC);
    else if (edge_evt)                 gap <= '0;
    else if (gap != GW'(EDGE_CYC))     gap <= gap + 1'b1;
  end

  // cycles the staged word has been on the lines, saturating
  always_ff @(posedge clk) begin
    if (rst || edge_evt)                        stg <= '0;
    else if (load_evt && stg != SW'(SETUP_CYC)) stg <= stg + 1'b1;
  end

  assign edge_ok  = (gap >= GW'(EDGE_CYC - 1));
  assign load_ok  = (gap >= GW'(HOLD_CYC - 1));
  assign setup_ok = (stg == SW'(SETUP_CYC));

  AST_GAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    (edge_evt && EDGE_CYC > 1) |=> !edge_ok); // R5

endmodule

// File: rtl/ubrst_sender.sv
module ubrst_sender
  import ubrst_pkg::*;
#(
  parameter int unsigned CLK_PS   = 4000,
  parameter int unsigned CNT_W    = 16,
  parameter logic [15:0] CRC_SEED = 16'h4ABA,
  parameter int unsigned HALF_PS  = 30000,
  parameter int unsigned DSU_PS   = 6000,
  parameter int unsigned DHO_PS   = 6000,
  parameter int unsigned CVH_PS   = 6200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  word_cnt,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_data,
  output logic              src_take,
  output logic              dmarq,
  input  logic              dmack,
  input  logic              host_rdy,
  input  logic              host_stop,
  output logic              dstrobe,
  output logic [WORD_W-1:0] dd_out,
  output logic              bus_oe
);

  localparam int unsigned HALF_RAW  = (HALF_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned SETUP_RAW = (DSU_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned HOLD_RAW  = (DHO_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned CVH_RAW   = (CVH_PS + CLK_PS - 1) / CLK_PS;
  localparam int unsigned HALF_CYC  = (HALF_RAW  < 2) ? 2 : HALF_RAW;
  localparam int unsigned SETUP_CYC = (SETUP_RAW < 1) ? 1 : SETUP_RAW;
  localparam int unsigned HOLD_CYC  = (HOLD_RAW  < 1) ? 1 : HOLD_RAW;
  localparam int unsigned CVH_CYC   = (CVH_RAW   < 1) ? 1 : CVH_RAW;
  localparam int unsigned HW        = $clog2(CVH_CYC + 1);
  localparam int unsigned CW        = $clog2(HALF_CYC + 2);

  ubrst_st_e         st;
  logic [CNT_W-1:0]  cnt;
  logic [HW-1:0]     hcnt;
  logic              strb_q;
  logic [WORD_W-1:0] dd_q;
  logic              edge_ok, load_ok, setup_ok;
  logic              fire, load, park_edge, enter, edge_evt;
  logic [15:0]       crc;

  assign enter     = (st == ST_REQ) && dmack && !host_stop;
  assign fire      = (st == ST_XFER) && dmack && host_rdy && !host_stop &&
                     (cnt != '0) && src_valid && edge_ok && setup_ok;
  assign load      = (st == ST_XFER) && src_valid && load_ok && (cnt != '0);
  assign park_edge = (st == ST_PARK) && !strb_q && edge_ok;
  assign edge_evt  = fire || park_edge || enter;

  ubrst_pace #(
    .EDGE_CYC (HALF_CYC),
    .HOLD_CYC (HOLD_CYC),
    .SETUP_CYC(SETUP_CYC)
  ) i_pace (
    .clk     (clk),
    .rst     (rst),
    .edge_evt(edge_evt),
    .load_evt(load),
    .edge_ok (edge_ok),
    .load_ok (load_ok),
    .setup_ok(setup_ok)
  );

  ubrst_crc #(.SEED(CRC_SEED)) i_crc (
    .clk    (clk),
    .rst    (rst),
    .seed_ld((st == ST_IDLE) && start && (word_cnt != '0)),
    .upd    (fire),
    .word   (dd_q),
    .crc    (crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      hcnt   <= '0;
      dmarq  <= 1'b0;
      strb_q <= 1'b1;
      dd_q   <= '0;
      bus_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start && word_cnt != '0) begin
          cnt   <= word_cnt;
          dmarq <= 1'b1;
          st    <= ST_REQ;
        end
        ST_REQ: if (enter) begin
          bus_oe <= 1'b1;
          strb_q <= 1'b1;
          st     <= ST_XFER;
        end
        ST_XFER: begin
          if (host_stop) begin
            dmarq <= 1'b0;
            st    <= ST_PARK;
          end else if (cnt == '0) begin
            dmarq <= 1'b0;
            st    <= ST_WSTOP;
          end else begin
            if (load) dd_q <= src_data;
            if (fire) begin
              strb_q <= ~strb_q;
              cnt    <= cnt - 1'b1;
            end
          end
        end
        ST_WSTOP: if (host_stop) st <= ST_PARK;
        ST_PARK: begin
          if (park_edge) strb_q <= 1'b1;
          else if (strb_q && load_ok) begin
            dd_q <= crc;
            st   <= ST_CRC;
          end
        end
        ST_CRC: if (!dmack) begin
          hcnt <= '0;
          st   <= ST_REL;
        end
        ST_REL: begin
          if (hcnt == HW'(CVH_CYC - 1)) begin
            bus_oe <= 1'b0;
            st     <= ST_IDLE;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign src_take = fire;
  assign dstrobe  = strb_q;
  assign dd_out   = dd_q;

  // independent edge-spacing tracker for the assertions
  logic          strb_d;
  logic [CW-1:0] se;
  always_ff @(posedge clk) begin
    if (rst) begin
      strb_d <= 1'b1;
      se     <= CW'(HALF_CYC + 1);
    end else begin
      strb_d <= strb_q;
      if (strb_q != strb_d)                se <= CW'(1);
      else if (se != CW'(HALF_CYC + 1))    se <= se + 1'b1;
    end
  end

  AST_EDGE_SPACING: assert property (@(posedge clk) disable iff (rst)
    (strb_q != strb_d) |-> (se >= CW'(HALF_CYC))); // R5
  AST_DATA_SETUP: assert property (@(posedge clk) disable iff (rst)
    (strb_q != strb_d) |-> $stable(dd_q)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((strb_q != strb_d) && HOLD_CYC > 1) |=> $stable(dd_q)); // R6
  AST_NO_EDGE_PAUSED: assert property (@(posedge clk) disable iff (rst)
    (($past(st) == ST_XFER) && (strb_q != $past(strb_q))) |-> $past(host_rdy)); // R7
  AST_TAKE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    src_take |=> (strb_q != $past(strb_q))); // R4
  AST_PARKED_WAIT: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == ST_WSTOP) |-> ($stable(strb_q) && !dmarq)); // R9
  AST_CRC_HELD: assert property (@(posedge clk) disable iff (rst)
    (($past(st) == ST_CRC) && (st == ST_CRC)) |-> $stable(dd_q)); // R10

endmodule

// File: tb/test_ubrst_sender.sv
module test_ubrst_sender;

  localparam int HALF  = 8;  // ceil(30 ns / 4 ns)
  localparam int SETUP = 2;  // ceil(6 ns / 4 ns)
  localparam int HOLD  = 2;
  localparam logic [15:0] SEED = 16'h4ABA;

  logic        clk = 1'b0;
  logic        rst, start, src_valid, dmack, host_rdy, host_stop;
  logic [15:0] word_cnt, src_data, dd_out;
  logic        src_take, dmarq, dstrobe, bus_oe;

  always #2 clk = ~clk;

  ubrst_sender i_ubrst_sender (
    .clk(clk), .rst(rst), .start(start), .word_cnt(word_cnt),
    .src_valid(src_valid), .src_data(src_data), .src_take(src_take),
    .dmarq(dmarq), .dmack(dmack), .host_rdy(host_rdy), .host_stop(host_stop),
    .dstrobe(dstrobe), .dd_out(dd_out), .bus_oe(bus_oe)
  );

  int tests = 0, fails = 0, wd = 0, n_seen = 0;
  logic [15:0] src_q[$];
  logic [15:0] exp_q[$];
  logic [15:0] crc_b;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r = c ^ d;
    repeat (16) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  // source model: pop one negedge after the take is seen
  bit take_prev = 0;
  always @(negedge clk) begin
    if (take_prev && src_q.size() > 0) void'(src_q.pop_front());
    take_prev = src_take;
    src_valid = (src_q.size() > 0);
    src_data  = (src_q.size() > 0) ? src_q[0] : 16'h0;
  end

  // monitor / scoreboard
  logic        prev_s, prev_rdy;
  logic [15:0] prev_dd, w;
  int          since_s, since_d;
  bit          ch, dch;
  always @(negedge clk) begin
    if (rst) begin
      prev_s = 1'b1; prev_dd = 16'h0; prev_rdy = 1'b1; since_s = 100; since_d = 100;
    end else begin
      ch  = (dstrobe != prev_s);
      dch = (dd_out != prev_dd);
      since_s++; since_d++;
      if (dmack) begin
        if (ch) begin
          chk(since_s >= HALF, "R5", "edge spacing", since_s, HALF);
          chk(!dch && since_d >= SETUP, "R6", "setup before edge", since_d, SETUP);
          if (dmarq) begin
            chk(prev_rdy, "R7", "edge without ready", prev_rdy, 1);
            if (exp_q.size() == 0) chk(0, "R4", "unexpected word", dd_out, 0);
            else begin
              w = exp_q.pop_front();
              chk(dd_out == w, "R4", "word order", dd_out, w);
            end
            crc_b = crc_ref(crc_b, dd_out);
            n_seen++;
          end
        end else if (dch) begin
          chk(since_s >= HOLD, "R6", "hold after edge", since_s, HOLD);
        end
      end
      if (ch)  since_s = 0;
      if (dch) since_d = 0;
      prev_s = dstrobe; prev_dd = dd_out; prev_rdy = host_rdy;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_burst(input int n, input bit pause_en, input int stop_at);
    bit hterm = 0;
    int n_at;
    logic s;
    for (int i = 0; i < n; i++) begin
      src_q.push_back(16'(16'hA000 + i * 16'h1357 + n));
      exp_q.push_back(16'(16'hA000 + i * 16'h1357 + n));
    end
    crc_b = SEED; n_seen = 0;
    start = 1; word_cnt = 16'(n);
    tick(); start = 0;
    chk(dmarq == 1, "R2", "request after start", dmarq, 1);
    tick(3);
    chk(bus_oe == 0 && dmarq == 1, "R3", "bus idle before ack", bus_oe, 0);
    dmack = 1;
    tick();
    chk(bus_oe == 1 && dstrobe == 1, "R3", "bus driven after ack", {bus_oe, dstrobe}, 2'b11);
    for (int c = 0; c < 20000; c++) begin
      tick();
      if (!dmarq) break;
      if (stop_at > 0 && n_seen >= stop_at) begin
        host_stop = 1;
        tick();
        chk(dmarq == 0, "R8", "request drop on stop", dmarq, 0);
        hterm = 1;
        break;
      end
      if (pause_en) host_rdy = ($urandom_range(0, 3) != 0);
    end
    host_rdy = 1;
    if (hterm) begin
      n_at = n_seen;
      tick(20);
      chk(n_seen == n_at, "R8", "no words after stop", n_seen, n_at);
      chk(src_q.size() == n - n_seen, "R8", "unsent words kept", src_q.size(), n - n_seen);
    end else begin
      chk(n_seen == n, "R4", "word count", n_seen, n);
      s = dstrobe;
      tick(6);
      chk(dstrobe == s && dmarq == 0, "R9", "strobe parked until stop", dstrobe, s);
      host_stop = 1;
    end
    for (int i = 0; i < 50 && !dstrobe; i++) tick();
    chk(dstrobe == 1, "R9", "strobe back high", dstrobe, 1);
    tick(3);
    chk(dd_out == crc_b && bus_oe == 1, "R10", "crc word", dd_out, crc_b);
    dmack = 0;
    tick();
    chk(bus_oe == 1, "R11", "held 1 cycle after ack drop", bus_oe, 1);
    tick();
    chk(bus_oe == 1 && dd_out == crc_b, "R11", "held 2 cycles after ack drop", bus_oe, 1);
    tick();
    chk(bus_oe == 0, "R11", "released after hold", bus_oe, 0);
    host_stop = 0;
    src_q.delete(); exp_q.delete();
    tick(3);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      fails++;
      $display("FAIL R4 watchdog: actual %0d cycles expected completion", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; start = 0; word_cnt = 0; dmack = 0; host_rdy = 1; host_stop = 0;
    tick(4); rst = 0;
    tick();
    chk(dmarq == 0 && bus_oe == 0, "R1", "reset request/enable", {dmarq, bus_oe}, 0);
    chk(dstrobe == 1 && src_take == 0, "R1", "reset strobe/take", {dstrobe, src_take}, 2'b10);
    host_rdy = 0; host_stop = 1;
    tick(5);
    chk(dmarq == 0 && bus_oe == 0 && dstrobe == 1 && dd_out == 0, "R12", "idle ignores host lines",
        {dmarq, bus_oe, dstrobe}, 3'b001);
    host_rdy = 1; host_stop = 0;
    start = 1; word_cnt = 0;
    tick(); start = 0;
    tick(3);
    chk(dmarq == 0, "R2", "zero count ignored", dmarq, 0);
    run_burst(5, 0, 0);
    run_burst(24, 1, 0);
    run_burst(40, 1, 12);
    run_burst(3, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule